// File: doc/BRIEF.md
# Single-Bit Shift/Rotate Unit

This block moves an 8-bit register value by one position, left or right, and supplies the bit that enters the vacated end from one of five sources: the incoming carry flag, the operand's top bit, the operand's bottom bit, a constant zero or a constant one. The bit that falls off the far end is always the new carry. The same encoding therefore gives logical shifts, arithmetic shifts, rotates and rotates through carry, and nothing else in the opcode has to distinguish them.

The unit takes the full 18-bit instruction word and uses only its low four bits. Bit 3 picks the direction and bits 2..0 pick the fill source. The outputs are registered, so a result, carry and zero flag appear one clock after the operand and instruction are presented. Register write-back and opcode decode belong to the surrounding datapath.

Top module: `shift_rotate_unit`

## Requirements
- R1: With instruction bit 3 at 0 (left), result bits 7..1 equal operand bits 6..0 and the fill bit enters result bit 0.
- R2: With instruction bit 3 at 1 (right), result bits 6..0 equal operand bits 7..1 and the fill bit enters result bit 7.
- R3: carry_out equals the bit shifted out: operand bit 7 on a left shift, operand bit 0 on a right shift.
- R4: The fill bit is chosen by instruction bits 2..0: 00x gives carry_in, 01x gives operand bit 7, 10x gives operand bit 0, 110 gives 0 and 111 gives 1. Bit 0 has no effect in the first three codes.
- R5: Code 01x on a left shift is a rotate left. Code 10x on a right shift is a rotate right.
- R6: zero_out is 1 exactly when the registered 8-bit result is 0x00.
- R7: Instruction bits 17..4 have no effect on any output.
- R8: Outputs are registered with one clock of latency. A clock edge that sees rst_n low sets result to 0x00, carry_out to 0 and zero_out to 1.
- R9: Starting from 0x0F with the carry fed back, the right-shift codes fill-0, fill-top, fill-1, fill-top, fill-carry and fill-carry give 0x07, 0x03, 0x81, 0xC0 (carry 1), 0xE0 (carry 0) and 0x70.
- R10: Starting from 0xF0 with the carry fed back, the left-shift codes fill-0, fill-bottom, fill-1, fill-bottom, fill-carry and fill-carry give 0xE0, 0xC0, 0x81, 0x03 (carry 1), 0x07 (carry 0) and 0x0E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 18 | Instruction word; bit 3 is the direction, bits 2..0 are the fill select |
| operand | input | 8 | Register value to shift |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Shifted value, registered |
| carry_out | output | 1 | Bit shifted out, registered |
| zero_out | output | 1 | Set when result is zero, registered |

## Verification
The hardest cases to reach are the through-carry chains, where each step depends on the carry left by the one before. The ports alone never form such a chain, because the carry input is free. The bench closes the loop itself: it feeds each registered carry_out back as the next carry_in and runs the two six-step sequences from R9 and R10. Around those chains it sweeps every operand, both carry values and all sixteen direction/fill codes, while the ignored high instruction bits change from step to step.

// File: rtl/ssr_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes the fill selector is three bits wide: a two-bit source class
// followed by a constant bit that only matters for the constant class.
package ssr_pkg;

    // Source class of the bit that enters the vacated end
    typedef enum logic [1:0] {
        FILL_CARRY = 2'b00,
        FILL_MSB   = 2'b01,
        FILL_LSB   = 2'b10,
        FILL_CONST = 2'b11
    } fill_src_e;

    // Decoded control for one operation
    typedef struct packed {
        logic      shift_right;
        fill_src_e src;
        logic      const_val;
    } shift_ctrl_t;

endpackage

// File: rtl/ssr_decode.sv
// Pulls the direction and fill-select fields out of the instruction word.
// Assumes the three select bits start at SEL_LSB and the direction bit
// sits directly above them. All other instruction bits are ignored.
module ssr_decode #(
    parameter int INSTR_W = 18,
    parameter int SEL_LSB = 0
) (
    input  logic [INSTR_W-1:0]  instr,
    output ssr_pkg::shift_ctrl_t ctrl
);
    localparam int DIR_POS = SEL_LSB + 3;
    localparam int HI_LSB  = DIR_POS + 1;

    // Field extraction
    always_comb begin
        ctrl.shift_right = instr[DIR_POS];
        ctrl.src         = ssr_pkg::fill_src_e'(instr[SEL_LSB+2:SEL_LSB+1]);
        ctrl.const_val   = instr[SEL_LSB];
    end

    // Bits outside the control field are deliberately ignored
    generate
        if (HI_LSB < INSTR_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^instr[INSTR_W-1:HI_LSB];
        end
        if (SEL_LSB > 0) begin : g_lo
            logic unused_lo;
            assign unused_lo = ^instr[SEL_LSB-1:0];
        end
    endgenerate
endmodule

// File: rtl/ssr_fill_mux.sv
// Chooses the bit that enters the vacated end of the register.
// Needs only the operand's two end bits and the current carry flag.
module ssr_fill_mux (
    input  ssr_pkg::shift_ctrl_t ctrl,
    input  logic                 operand_msb,
    input  logic                 operand_lsb,
    input  logic                 carry_in,
    output logic                 fill_bit
);
    // Four-way select on the source class
    always_comb begin
        unique case (ctrl.src)
            ssr_pkg::FILL_CARRY: fill_bit = carry_in;
            ssr_pkg::FILL_MSB:   fill_bit = operand_msb;
            ssr_pkg::FILL_LSB:   fill_bit = operand_lsb;
            default:             fill_bit = ctrl.const_val;
        endcase
    end
endmodule

// File: rtl/ssr_shifter.sv
// Moves the operand by one bit in either direction and inserts the fill bit.
// Each result bit is a 2:1 mux between its two neighbours, with the fill bit
// taking the place of the missing neighbour at each end.
module ssr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              shift_right,
    input  logic              fill_bit,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] shifted,
    output logic              shifted_out
);
    localparam int TOP = DATA_W - 1;

    // Per-bit neighbour select
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic from_below;
            logic from_above;
            if (i == 0) begin : g_low_end
                assign from_below = fill_bit;
            end else begin : g_low_mid
                assign from_below = operand[i-1];
            end
            if (i == TOP) begin : g_high_end
                assign from_above = fill_bit;
            end else begin : g_high_mid
                assign from_above = operand[i+1];
            end
            assign shifted[i] = shift_right ? from_above : from_below;
        end
    endgenerate

    // The end bit that leaves the register
    always_comb begin
        shifted_out = shift_right ? operand[0] : operand[TOP];
    end
endmodule

// File: rtl/ssr_zero_detect.sv
// Flags an all-zero word. Built as a two-level OR so the depth stays
// shallow for wider datapaths.
module ssr_zero_detect #(
    parameter int DATA_W = 8,
    parameter int GROUP  = 4
) (
    input  logic [DATA_W-1:0] value,
    output logic              is_zero
);
    localparam int NGRP = (DATA_W + GROUP - 1) / GROUP;

    logic [NGRP-1:0] grp_any;

    // First level: OR within each group
    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int LO = g * GROUP;
            localparam int HI = (LO + GROUP - 1 < DATA_W) ? LO + GROUP - 1 : DATA_W - 1;
            assign grp_any[g] = |value[HI:LO];
        end
    endgenerate

    // Second level: no group has a set bit
    always_comb begin
        is_zero = ~|grp_any;
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// One-bit shift/rotate unit with a selectable fill source and a registered
// result, carry and zero flag. Inputs are sampled on every rising clock edge.
// Reset is synchronous and active low.
module shift_rotate_unit #(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 18,
    parameter int SEL_LSB = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  operand,
    input  logic               carry_in,
    output logic [DATA_W-1:0]  result,
    output logic               carry_out,
    output logic               zero_out
);
    ssr_pkg::shift_ctrl_t ctrl;
    logic                 fill_bit;
    logic [DATA_W-1:0]    next_result;
    logic                 next_carry;
    logic                 next_zero;

    ssr_decode #(.INSTR_W(INSTR_W), .SEL_LSB(SEL_LSB)) u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    ssr_fill_mux u_fill (
        .ctrl        (ctrl),
        .operand_msb (operand[DATA_W-1]),
        .operand_lsb (operand[0]),
        .carry_in    (carry_in),
        .fill_bit    (fill_bit)
    );

    ssr_shifter #(.DATA_W(DATA_W)) u_shift (
        .shift_right (ctrl.shift_right),
        .fill_bit    (fill_bit),
        .operand     (operand),
        .shifted     (next_result),
        .shifted_out (next_carry)
    );

    ssr_zero_detect #(.DATA_W(DATA_W)) u_zero (
        .value   (next_result),
        .is_zero (next_zero)
    );

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= 1'b0;
            zero_out  <= 1'b1;
        end else begin
            result    <= next_result;
            carry_out <= next_carry;
            zero_out  <= next_zero;
        end
    end
endmodule

// File: rtl/ssr_checker.sv
// Timing properties of the shift/rotate unit, observed at its ports only.
module ssr_checker #(
    parameter int DATA_W  = 8,
    parameter int INSTR_W = 18,
    parameter int SEL_LSB = 0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic [DATA_W-1:0]  operand,
    input logic               carry_in,
    input logic [DATA_W-1:0]  result,
    input logic               carry_out,
    input logic               zero_out
);
    localparam int DIR_POS = SEL_LSB + 3;

    logic       dir_r;
    logic [1:0] cls;
    logic       kbit;
    logic       unused_instr;
    assign dir_r        = instr[DIR_POS];
    assign cls          = instr[SEL_LSB+2:SEL_LSB+1];
    assign kbit         = instr[SEL_LSB];
    assign unused_instr = ^instr;

    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !carry_out && zero_out);

    a_r1_left_body: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_r |=> result[DATA_W-1:1] == $past(operand[DATA_W-2:0]));

    a_r2_right_body: assert property (@(posedge clk) disable iff (!rst_n)
        dir_r |=> result[DATA_W-2:0] == $past(operand[DATA_W-1:1]));

    a_r3_carry_left: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_r |=> carry_out == $past(operand[DATA_W-1]));

    a_r3_carry_right: assert property (@(posedge clk) disable iff (!rst_n)
        dir_r |=> carry_out == $past(operand[0]));

    a_r4_const_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_r && cls == 2'b11) |=> result[0] == $past(kbit));

    a_r4_carry_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_r && cls == 2'b00) |=> result[DATA_W-1] == $past(carry_in));

    a_r5_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_r && cls == 2'b01) |=>
        result == {$past(operand[DATA_W-2:0]), $past(operand[DATA_W-1])});

    a_r5_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_r && cls == 2'b10) |=>
        result == {$past(operand[0]), $past(operand[DATA_W-1:1])});

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        zero_out == (result == '0));
endmodule

bind shift_rotate_unit ssr_checker #(
    .DATA_W(DATA_W), .INSTR_W(INSTR_W), .SEL_LSB(SEL_LSB)
) u_ssr_checker (.*);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [17:0] instr;
    logic [7:0]  operand;
    logic        carry_in;
    logic [7:0]  result;
    logic        carry_out;
    logic        zero_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shift_rotate_unit dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .operand(operand),
        .carry_in(carry_in), .result(result), .carry_out(carry_out),
        .zero_out(zero_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference from R1..R4: returns {result, carry}
    function automatic logic [8:0] model(input logic [3:0] ctl, input logic [7:0] op,
                                         input logic cin);
        logic f;
        case (ctl[2:1])
            2'b00:   f = cin;
            2'b01:   f = op[7];
            2'b10:   f = op[0];
            default: f = ctl[0];
        endcase
        if (ctl[3]) return {f, op[7:1], op[0]};
        else        return {op[6:0], f, op[7]};
    endfunction

    // Present inputs at a falling edge, read outputs at the next falling edge
    task automatic step(input logic [13:0] hi, input logic [3:0] ctl,
                        input logic [7:0] op, input logic cin);
        @(negedge clk);
        instr    = {hi, ctl};
        operand  = op;
        carry_in = cin;
        @(negedge clk);
    endtask

    // Six-step chain with the carry fed back
    task automatic chain(input string tag, input logic [7:0] start,
                         input logic [23:0] ctls, input logic [47:0] exps);
        logic [7:0] v;
        logic       c;
        v = start;
        c = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step(14'h1555, ctls[23-4*k -: 4], v, c);
            chk(tag, result, exps[47-8*k -: 8]);
            v = result;
            c = carry_out;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] e;
        logic [8:0] e2;
        rst_n    = 1'b0;
        instr    = 18'h3FFFF;
        operand  = 8'hA5;
        carry_in = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 result", result, 0);
        chk("R8 carry", carry_out, 0);
        chk("R8 zero", zero_out, 1);
        rst_n = 1'b1;

        // R9, R10: fixed sequences (codes: dir bit 3, fill bits 2..0)
        chain("R9", 8'h0F, {4'b1110, 4'b1010, 4'b1111, 4'b1010, 4'b1000, 4'b1000},
              {8'h07, 8'h03, 8'h81, 8'hC0, 8'hE0, 8'h70});
        step(14'h0, 4'b1000, 8'hC0, 1'b1);
        chk("R9 carry after fill-top", carry_out, 0);
        step(14'h0, 4'b1010, 8'h81, 1'b0);
        chk("R9 carry 1", carry_out, 1);
        chain("R10", 8'hF0, {4'b0110, 4'b0100, 4'b0111, 4'b0100, 4'b0000, 4'b0000},
              {8'hE0, 8'hC0, 8'h81, 8'h03, 8'h07, 8'h0E});
        step(14'h0, 4'b0100, 8'h81, 1'b0);
        chk("R10 carry 1", carry_out, 1);

        // Exhaustive sweep: all operands, carries and control codes
        for (int op = 0; op < 256; op++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int ctl = 0; ctl < 16; ctl++) begin
                    logic [13:0] hi;
                    hi = 14'((op * 37) ^ (ctl * 911) ^ (ci * 5003));
                    e  = model(4'(ctl), 8'(op), ci[0]);
                    step(hi, 4'(ctl), 8'(op), ci[0]);
                    chk(ctl[3] ? "R2 result" : "R1 result", result, e[8:1]);
                    chk(ctl[3] ? "R4 fill right" : "R4 fill left",
                        ctl[3] ? result[7] : result[0], ctl[3] ? e[8] : e[1]);
                    chk("R3 carry", carry_out, e[0]);
                    chk("R6 zero", zero_out, (e[8:1] == 8'h00) ? 1 : 0);
                    if (ctl[3:1] == 3'b001)
                        chk("R5 rotate left", result, {op[6:0], op[7]});
                    if (ctl[3:1] == 3'b110)
                        chk("R5 rotate right", result, {op[0], op[7:1]});
                end
            end
        end

        // R7: high instruction bits all-zero vs all-one give the same outputs
        for (int n = 0; n < 16; n++) begin
            logic [7:0] op;
            op = 8'(n * 17 + 3);
            step(14'h0000, 4'(n), op, n[0]);
            e  = {result, carry_out};
            step(14'h3FFF, 4'(n), op, n[0]);
            e2 = {result, carry_out};
            chk("R7 ignored bits", e2, e);
            chk("R7 vs model", e2, model(4'(n), op, n[0]));
        end

        // R8: reset in mid-run clears outputs
        step(14'h0, 4'b0111, 8'hFF, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-run result", result, 0);
        chk("R8 mid-run carry", carry_out, 0);
        chk("R8 mid-run zero", zero_out, 1);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule